// File: doc/BRIEF.md
# Clock-Enable, Reset Filter and Low-Power Mode Controller

This block sits between the oscillator and a small 8-bit microcontroller core. It halves the oscillator rate to form a two-phase clock enable, counts those enables into machine cycles of twelve oscillator periods, and produces a single-cycle machine-cycle strobe. It also conditions the external reset pin. The pin passes through a synchroniser and must stay high for two whole machine cycles before the core reset is raised. The core reset follows the pin back down synchronously.

Software enters a low-power state by pulsing one of two request inputs when it writes the power-control register. The request takes effect at the next machine-cycle boundary, so the requesting instruction is the last one to complete. In the sleep state the CPU enable stops and the peripheral enable keeps running. An interrupt or a reset ends it. In the deep state every enable stops and the oscillator is told to halt. Only a filtered reset ends it, and a high reset pin re-enables the oscillator so that the filter can count.

Top module: `pwrClkCtl`

## Requirements
- R1: `periphClkEn` is high on exactly every second oscillator cycle while not in the deep state, and `cpuClkEn` matches it while running.
- R2: `machCycle` is a one-cycle pulse that coincides with a peripheral enable and recurs every 12 oscillator cycles (every 6th enable).
- R3: A reset pin held high for fewer than 24 consecutive oscillator samples never raises `coreRst`. With 24 or more, `coreRst` rises after the 26th oscillator edge counted from the first high sample.
- R4: `coreRst` stays high while the synchronised pin is high. It falls synchronously, so a pin held for N ≥ 24 samples gives a pulse of N−23 cycles.
- R5: While `porN` is low, `coreRst` is 1 and `cpuClkEn`, `periphClkEn`, `machCycle` and `oscStop` are 0.
- R6: A sleep request takes effect at the next `machCycle` boundary. After that, `cpuClkEn` stays 0 and `periphClkEn` keeps its divide-by-two pattern.
- R7: In the sleep state, `intPending` restores `cpuClkEn` on the next oscillator edge. Outside the sleep state, `intPending` has no effect.
- R8: If `intPending` is high at the boundary where a sleep request would take effect, the request is dropped and the CPU keeps its clock.
- R9: A deep request takes effect at the next boundary: `oscStop` goes to 1 and both enables and `machCycle` go to 0. A deep request wins over a sleep request given at the same time.
- R10: In the deep state, `intPending` is ignored. Only a filtered reset leaves the state, and after the reset the CPU runs again with `oscStop` at 0.
- R11: In the deep state, `oscStop` is 0 while the synchronised reset pin is high and returns to 1 if the pin drops before the filter fires.
- R12: `coreRst` clears any pending request, and requests made while `coreRst` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Oscillator clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstPin | input | 1 | External reset pin, asynchronous, active high |
| idleReq | input | 1 | One-cycle request to enter the sleep state |
| pdReq | input | 1 | One-cycle request to enter the deep state |
| intPending | input | 1 | An enabled interrupt is pending |
| cpuClkEn | output | 1 | Clock enable for the CPU |
| periphClkEn | output | 1 | Clock enable for peripherals |
| machCycle | output | 1 | Machine-cycle boundary strobe |
| oscStop | output | 1 | Request to halt the oscillator |
| coreRst | output | 1 | Filtered, synchronously released core reset |

## Verification
Two pairs of events can land in the same oscillator cycle. An interrupt can arrive at the boundary where a sleep request is applied, and a reset can arrive while a mode request is waiting. The bench provokes the first pair by holding `intPending` high across the boundary while it pulses the sleep request. It judges the result by counting CPU enables afterwards, which must not pause. It provokes the second pair by pulsing both requests while the filtered reset is high, then checking over two machine cycles that neither mode is ever entered. Random reset-pin pulse lengths on either side of the 24-sample threshold are checked against the expected onset and width of the reset.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

  // Strobes the controller hands to the datapath
  typedef struct packed {
    logic mcClear;    // hold machine-cycle counter at phase zero
    logic holdClear;  // restart the reset-pin hold counter
  } ctlStrobe_t;

  // Status the datapath returns to the controller
  typedef struct packed {
    logic tick;       // divided-by-two enable
    logic mcStrobe;   // last tick of a machine cycle
    logic pinSync;    // synchronised reset pin
    logic holdFull;   // pin has been high for the full hold window
  } dpStatus_t;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_DEEP  = 2'd2
  } modeState_t;

endpackage

// File: rtl/pmc_datapath.sv
`timescale 1ns/1ps
module pmcDatapath
  import pmc_pkg::*;
#(
  parameter int OSC_PER_MC  = 12,
  parameter int RST_HOLD_MC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstPin,
  input  ctlStrobe_t ctl,
  output dpStatus_t  stat
);

  localparam int TICKS_PER_MC = OSC_PER_MC / 2;
  localparam int MC_W         = (TICKS_PER_MC > 1) ? $clog2(TICKS_PER_MC) : 1;
  localparam int HOLD_OSC     = OSC_PER_MC * RST_HOLD_MC;
  localparam int HOLD_W       = $clog2(HOLD_OSC + 1);
  localparam logic [MC_W-1:0]   MC_LAST   = MC_W'(TICKS_PER_MC - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_OSC - 1);

  // Divide-by-two: the enable is independent of the input duty cycle
  logic divPhase;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) divPhase <= 1'b0;
    else       divPhase <= ~divPhase;
  end

  // Reset pin synchroniser, depth chosen by parameter
  logic pinSync;
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncQ <= 1'b0;
        else       syncQ <= rstPin;
      end
      assign pinSync = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rstPin};
      end
      assign pinSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // Machine-cycle phase counter on the divided enable
  logic [MC_W-1:0] mcCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)            mcCnt <= '0;
    else if (ctl.mcClear) mcCnt <= '0;
    else if (divPhase)    mcCnt <= (mcCnt == MC_LAST) ? '0 : mcCnt + 1'b1;
  end

  // Hold counter: earlier cycles the synchronised pin has been high, saturating
  logic [HOLD_W-1:0] holdCnt;
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                   holdCnt <= '0;
    else if (ctl.holdClear)      holdCnt <= '0;
    else if (holdCnt != HOLD_LAST) holdCnt <= holdCnt + 1'b1;
  end

  always_comb begin
    stat.tick     = divPhase;
    stat.mcStrobe = divPhase && (mcCnt == MC_LAST);
    stat.pinSync  = pinSync;
    stat.holdFull = pinSync && (holdCnt == HOLD_LAST);
  end

endmodule

// File: rtl/pmc_control.sv
`timescale 1ns/1ps
module pmcControl
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       idleReq,
  input  logic       pdReq,
  input  logic       intPending,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl,
  output logic       cpuClkEn,
  output logic       periphClkEn,
  output logic       machCycle,
  output logic       oscStop,
  output logic       coreRst
);

  modeState_t state;
  logic sleepPend, deepPend;
  logic sleepNext, deepNext;

  assign sleepNext = sleepPend | idleReq;
  assign deepNext  = deepPend  | pdReq;

  // Filtered reset, set by the full window, released when the pin drops
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)              coreRst <= 1'b1;
    else if (stat.holdFull) coreRst <= 1'b1;
    else if (!stat.pinSync) coreRst <= 1'b0;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      state     <= MODE_RUN;
      sleepPend <= 1'b0;
      deepPend  <= 1'b0;
    end else if (coreRst) begin
      state     <= MODE_RUN;
      sleepPend <= 1'b0;
      deepPend  <= 1'b0;
    end else begin
      unique case (state)
        MODE_RUN: begin
          sleepPend <= sleepNext;
          deepPend  <= deepNext;
          if (stat.mcStrobe) begin
            if (deepNext) begin
              state     <= MODE_DEEP;
              sleepPend <= 1'b0;
              deepPend  <= 1'b0;
            end else if (sleepNext) begin
              sleepPend <= 1'b0;
              state     <= intPending ? MODE_RUN : MODE_SLEEP;
            end
          end
        end
        MODE_SLEEP: if (intPending) state <= MODE_RUN;
        MODE_DEEP:  state <= MODE_DEEP;
        default:    state <= MODE_RUN;
      endcase
    end
  end

  always_comb begin
    ctl.mcClear   = coreRst;
    ctl.holdClear = !stat.pinSync;
    cpuClkEn      = stat.tick && (state == MODE_RUN);
    periphClkEn   = stat.tick && (state != MODE_DEEP);
    machCycle     = stat.mcStrobe && (state != MODE_DEEP);
    oscStop       = (state == MODE_DEEP) && !stat.pinSync;
  end

endmodule

// File: rtl/pwrClkCtl.sv
`timescale 1ns/1ps
module pwrClkCtl
  import pmc_pkg::*;
#(
  parameter int OSC_PER_MC  = 12,
  parameter int RST_HOLD_MC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic oscClk,
  input  logic porN,
  input  logic rstPin,
  input  logic idleReq,
  input  logic pdReq,
  input  logic intPending,
  output logic cpuClkEn,
  output logic periphClkEn,
  output logic machCycle,
  output logic oscStop,
  output logic coreRst
);

  ctlStrobe_t ctlS;
  dpStatus_t  dpS;

  pmcDatapath #(
    .OSC_PER_MC (OSC_PER_MC),
    .RST_HOLD_MC(RST_HOLD_MC),
    .SYNC_STAGES(SYNC_STAGES)
  ) datapath_i (
    .clk   (oscClk),
    .porN  (porN),
    .rstPin(rstPin),
    .ctl   (ctlS),
    .stat  (dpS)
  );

  pmcControl control_i (
    .clk        (oscClk),
    .porN       (porN),
    .idleReq    (idleReq),
    .pdReq      (pdReq),
    .intPending (intPending),
    .stat       (dpS),
    .ctl        (ctlS),
    .cpuClkEn   (cpuClkEn),
    .periphClkEn(periphClkEn),
    .machCycle  (machCycle),
    .oscStop    (oscStop),
    .coreRst    (coreRst)
  );

endmodule

// File: rtl/pmc_checker.sv
`timescale 1ns/1ps
module pmcChecker #(
  parameter int OSC_PER_MC  = 12,
  parameter int RST_HOLD_MC = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic oscClk,
  input logic porN,
  input logic rstPin,
  input logic idleReq,
  input logic pdReq,
  input logic intPending,
  input logic cpuClkEn,
  input logic periphClkEn,
  input logic machCycle,
  input logic oscStop,
  input logic coreRst
);

  localparam int TICKS_PER_MC = OSC_PER_MC / 2;
  localparam int HOLD_OSC     = OSC_PER_MC * RST_HOLD_MC;
  localparam int RUN_W        = $clog2(HOLD_OSC + 1) + 1;
  localparam int TK_W         = $clog2(TICKS_PER_MC + 1) + 1;

  // Consecutive high samples of the raw pin, saturating
  logic [RUN_W-1:0] pinRun;
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN)                        pinRun <= '0;
    else if (!rstPin)                 pinRun <= '0;
    else if (pinRun < RUN_W'(HOLD_OSC)) pinRun <= pinRun + 1'b1;
  end

  // Peripheral enables since the last machine-cycle strobe
  logic [TK_W-1:0] tickCnt;
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN)            tickCnt <= '0;
    else if (coreRst)     tickCnt <= '0;
    else if (machCycle)   tickCnt <= '0;
    else if (periphClkEn) tickCnt <= tickCnt + 1'b1;
  end

  // Sticky flag: the deep state was seen and no reset has come yet
  logic inDeep;
  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN)        inDeep <= 1'b0;
    else if (coreRst) inDeep <= 1'b0;
    else if (oscStop) inDeep <= 1'b1;
  end

  assert_tick_alternates_R1: assert property (@(posedge oscClk) disable iff (!porN)
    periphClkEn |=> !periphClkEn);

  assert_cpu_needs_periph_R6: assert property (@(posedge oscClk) disable iff (!porN)
    cpuClkEn |-> periphClkEn);

  assert_mc_period_R2: assert property (@(posedge oscClk) disable iff (!porN || coreRst)
    machCycle |-> (periphClkEn && tickCnt == TK_W'(TICKS_PER_MC - 1)));

  assert_reset_needs_hold_R3: assert property (@(posedge oscClk) disable iff (!porN)
    $rose(coreRst) |-> ($past(pinRun, SYNC_STAGES) >= RUN_W'(HOLD_OSC)));

  assert_deep_quiet_R10: assert property (@(posedge oscClk) disable iff (!porN)
    inDeep |-> (!cpuClkEn && !periphClkEn && !machCycle));

  assert_reset_clears_mode_R12: assert property (@(posedge oscClk) disable iff (!porN)
    $past(coreRst) |-> !oscStop);

  assert_stop_quiet_R9: assert property (@(posedge oscClk) disable iff (!porN)
    oscStop |-> (!cpuClkEn && !periphClkEn));

endmodule

bind pwrClkCtl pmcChecker #(
  .OSC_PER_MC (OSC_PER_MC),
  .RST_HOLD_MC(RST_HOLD_MC),
  .SYNC_STAGES(SYNC_STAGES)
) chk_i (.*);

// File: tb/pwrClkCtl_tb_top.sv
`timescale 1ns/1ps
module pwrClkCtl_tb_top;

  localparam int HOLD  = 24;
  localparam int SYNC  = 2;
  localparam int MCLEN = 12;

  logic oscClk = 1'b0;
  logic porN = 1'b0, rstPin = 1'b0, idleReq = 1'b0, pdReq = 1'b0, intPending = 1'b0;
  logic cpuClkEn, periphClkEn, machCycle, oscStop, coreRst;

  int nChecks = 0;
  int nFail   = 0;

  always #10 oscClk = ~oscClk;

  pwrClkCtl dut_i (
    .oscClk(oscClk), .porN(porN), .rstPin(rstPin), .idleReq(idleReq), .pdReq(pdReq),
    .intPending(intPending), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn),
    .machCycle(machCycle), .oscStop(oscStop), .coreRst(coreRst)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expFirst(input int n);
    return (n >= HOLD) ? HOLD + SYNC : -1;
  endfunction

  function automatic int expWidth(input int n);
    return (n >= HOLD) ? n - HOLD + 1 : 0;
  endfunction

  // Count enables over n negedges
  task automatic observe(input int n, output int cpuN, output int perN,
                         output int mcN, output int stopN, output int altErr);
    int prev = -1;
    cpuN = 0; perN = 0; mcN = 0; stopN = 0; altErr = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge oscClk);
      cpuN  += int'(cpuClkEn);
      perN  += int'(periphClkEn);
      mcN   += int'(machCycle);
      stopN += int'(oscStop);
      if (prev == int'(periphClkEn)) altErr++;
      prev = int'(periphClkEn);
    end
  endtask

  task automatic waitBoundary();
    int guard = 0;
    do begin
      @(negedge oscClk);
      guard++;
    end while (!machCycle && guard < 40);
  endtask

  task automatic pulseTest(input int n, input string req);
    int first = -1;
    int width = 0;
    @(negedge oscClk);
    rstPin = 1'b1;
    for (int k = 1; k <= n + SYNC + 4; k++) begin
      @(negedge oscClk);
      if (coreRst) begin
        if (first < 0) first = k;
        width++;
      end
      if (k == n) rstPin = 1'b0;
    end
    checkEq({req, " width"}, width, expWidth(n));
    if (n >= HOLD) checkEq({req, " onset"}, first, expFirst(n));
    repeat (4) @(negedge oscClk);
  endtask

  task automatic pulseReq(input bit sleepR, input bit deepR);
    @(negedge oscClk);
    idleReq = sleepR;
    pdReq   = deepR;
    @(negedge oscClk);
    idleReq = 1'b0;
    pdReq   = 1'b0;
  endtask

  initial begin
    int cpuN, perN, mcN, stopN, altErr, gap;
    void'($urandom(32'd1701));

    // R5: power-on state
    repeat (3) @(negedge oscClk);
    checkEq("R5 coreRst in por", int'(coreRst), 1);
    checkEq("R5 enables in por", int'(cpuClkEn | periphClkEn | machCycle), 0);
    checkEq("R5 oscStop in por", int'(oscStop), 0);
    porN = 1'b1;
    repeat (4) @(negedge oscClk);
    checkEq("R4 release after por", int'(coreRst), 0);

    // R1 / R2: running pattern
    observe(24, cpuN, perN, mcN, stopN, altErr);
    checkEq("R1 periph count", perN, 12);
    checkEq("R1 cpu count", cpuN, 12);
    checkEq("R1 alternation", altErr, 0);
    checkEq("R2 strobes in 24 cycles", mcN, 2);
    waitBoundary();
    gap = 0;
    do begin @(negedge oscClk); gap++; end while (!machCycle && gap < 40);
    checkEq("R2 strobe spacing", gap, MCLEN);

    // R7: interrupt while running has no effect
    intPending = 1'b1;
    observe(12, cpuN, perN, mcN, stopN, altErr);
    intPending = 1'b0;
    checkEq("R7 int while running", cpuN, 6);

    // R3 / R4 directed thresholds
    pulseTest(HOLD - 1, "R3 short pulse");
    pulseTest(HOLD, "R3 exact hold");
    pulseTest(HOLD + 5, "R4 long hold");

    // R3 / R4 random lengths
    for (int i = 0; i < 6; i++) begin
      int n = 14 + int'($urandom % 22);
      pulseTest(n, "R3 random pulse");
    end

    // R6 sleep entry, R7 wake
    pulseReq(1'b1, 1'b0);
    waitBoundary();
    observe(12, cpuN, perN, mcN, stopN, altErr);
    checkEq("R6 cpu off in sleep", cpuN, 0);
    checkEq("R6 periph in sleep", perN, 6);
    checkEq("R6 alternation in sleep", altErr, 0);
    @(negedge oscClk); intPending = 1'b1;
    @(negedge oscClk); intPending = 1'b0;
    observe(12, cpuN, perN, mcN, stopN, altErr);
    checkEq("R7 wake by interrupt", cpuN, 6);

    // R8: interrupt at the boundary cancels sleep
    @(negedge oscClk);
    intPending = 1'b1;
    pulseReq(1'b1, 1'b0);
    waitBoundary();
    observe(12, cpuN, perN, mcN, stopN, altErr);
    checkEq("R8 cpu keeps running", cpuN, 6);
    intPending = 1'b0;
    observe(28, cpuN, perN, mcN, stopN, altErr);
    checkEq("R8 request dropped", cpuN, 14);

    // R9: deep entry, deep wins over sleep
    pulseReq(1'b1, 1'b1);
    waitBoundary();
    observe(12, cpuN, perN, mcN, stopN, altErr);
    checkEq("R9 oscStop set", stopN, 12);
    checkEq("R9 enables off", cpuN + perN + mcN, 0);

    // R10: interrupt ignored in deep
    @(negedge oscClk); intPending = 1'b1;
    observe(8, cpuN, perN, mcN, stopN, altErr);
    intPending = 1'b0;
    checkEq("R10 int ignored in deep", cpuN + perN, 0);
    checkEq("R10 still stopped", stopN, 8);

    // R11: short pin pulse restarts oscillator only while high
    @(negedge oscClk); rstPin = 1'b1;
    repeat (5) @(negedge oscClk);
    checkEq("R11 oscStop low with pin", int'(oscStop), 0);
    checkEq("R11 enables off with pin", int'(cpuClkEn | periphClkEn), 0);
    repeat (5) @(negedge oscClk); rstPin = 1'b0;
    repeat (5) @(negedge oscClk);
    checkEq("R11 oscStop back", int'(oscStop), 1);
    checkEq("R11 no reset", int'(coreRst), 0);

    // R10: filtered reset exits deep
    pulseTest(HOLD + 6, "R10 reset from deep");
    observe(12, cpuN, perN, mcN, stopN, altErr);
    checkEq("R10 cpu after reset", cpuN, 6);
    checkEq("R10 oscStop after reset", stopN, 0);

    // R12: requests during reset ignored
    @(negedge oscClk); rstPin = 1'b1;
    repeat (HOLD + SYNC + 2) @(negedge oscClk);
    checkEq("R12 reset active", int'(coreRst), 1);
    pulseReq(1'b1, 1'b1);
    @(negedge oscClk); rstPin = 1'b0;
    repeat (4) @(negedge oscClk);
    observe(30, cpuN, perN, mcN, stopN, altErr);
    checkEq("R12 cpu runs", cpuN, 15);
    checkEq("R12 no stop", stopN, 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule